// File: doc/BRIEF.md
# Calibrated Hit Timestamp Assembler

This block turns the raw results of a two-stage time interpolator into a picosecond timestamp. It owns a free-running coarse counter on the system clock. When a channel's end-of-conversion strobe is seen, the block takes the counter value, the 2-bit phase-region code and the oscillation count. It then forms one timestamp in units of 1/16 ps. The coarse term is pulled back by the oscillation count, because the conversion ends that many system cycles after the hit. The fine term is looked up bin by bin in loadable tables of calibrated bin widths. Each table answers with the running sum of the widths below the current bin, and the ultra-fine table adds half of the current bin on top.

Two identical channels, one for start and one for stop, share the coarse counter. Each stop result also yields an interval against the most recent start result. The coarse difference is taken modulo the counter width, so a counter wrap between start and stop does no harm. A configuration bit tells the block whether the oscillator is faster or slower than the system clock, which sets the fine-region offset and the sign of the ultra-fine term. A plain write port fills the width tables. Deriving those widths from histograms is done elsewhere.

Top module: `hit_timestamp_assembler`

## Requirements
- R1: The coarse counter is CW bits wide (default 16). It is 0 after reset, adds one on every clock and wraps from all-ones to zero. A conversion uses the counter value c held in the cycle in which its end-of-conversion input is high. Its coarse term is (c − u) mod 2^CW, where u is the raw oscillation count.
- R2: After reset, all valid outputs are low and the timestamp and interval outputs are zero. A channel's valid output is high for exactly one cycle per end-of-conversion cycle. That cycle is the one after the third rising edge, counted from the edge that samples end-of-conversion.
- R3: With the slow-oscillator bit at 0, timestamp = coarse·(TCLK_PS·16) + F(f) + U(u) modulo 2^(CW+16). F(k) is the sum of fine widths at table addresses 0..k−1, and f is the 2-bit region code 0..3. U(u) is the sum of ultra-fine widths at addresses 0..u−2 plus the width at address u−1 shifted right by one. All widths are in 1/16 ps.
- R4: With the slow-oscillator bit at 1, timestamp = coarse·(TCLK_PS·16) + F(f+1) − U(u), in two's complement modulo 2^(CW+16).
- R5: The ultra-fine count u is 5 bits. U(0) = 0, and any u above UBINS (default 27) is looked up as UBINS. The coarse correction always uses the raw u.
- R6: A write with cal_we high stores cal_data in one table entry. cal_chan selects the channel (0 start, 1 stop) and cal_tbl selects the table (0 fine, 1 ultra-fine). Valid fine addresses are 0..3 and valid ultra-fine addresses are 0..UBINS−1; writes to other addresses change nothing. After reset, fine entries hold 8000 (500 ps) and ultra-fine entries hold 320 (20 ps).
- R7: With every stop timestamp, iv_valid is high in the same cycle. iv = ((cs − cb) mod 2^CW)·(TCLK_PS·16) + (Ps − Pb) as a 33-bit two's complement value. Here cs and Ps are the stop's coarse term and fine sum, and cb and Pb belong to the most recent start conversion, including one sampled in the same cycle as the stop. Before any start, cb and Pb are 0.
- R8: The slow-oscillator bit is taken in the same cycle as end-of-conversion; later changes do not alter that conversion's result.
- R9: Conversions on consecutive cycles, on either or both channels, each produce their own correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slow | input | 1 | 1 when the oscillator is slower than the system clock |
| start_eoc | input | 1 | Start channel end-of-conversion |
| start_fine | input | 2 | Start channel phase-region code |
| start_ufc | input | UW (5) | Start channel oscillation count |
| stop_eoc | input | 1 | Stop channel end-of-conversion |
| stop_fine | input | 2 | Stop channel phase-region code |
| stop_ufc | input | UW (5) | Stop channel oscillation count |
| cal_we | input | 1 | Table write enable |
| cal_chan | input | 1 | Table channel: 0 start, 1 stop |
| cal_tbl | input | 1 | Table select: 0 fine, 1 ultra-fine |
| cal_addr | input | UW (5) | Table entry address |
| cal_data | input | WW (16) | Bin width in 1/16 ps |
| start_ts_valid | output | 1 | Start timestamp strobe |
| start_ts | output | CW+16 (32) | Start timestamp, 1/16 ps |
| stop_ts_valid | output | 1 | Stop timestamp strobe |
| stop_ts | output | CW+16 (32) | Stop timestamp, 1/16 ps |
| iv_valid | output | 1 | Interval strobe |
| iv | output | CW+17 (33) | Stop minus start, two's complement, 1/16 ps |

## Verification
The bench targets several corners. Oscillation counts of 0, 28 and 31 check the clamp of the ultra-fine lookup; a missing clamp would index past the table and yield garbage. A conversion a few cycles after reset makes c − u negative, and a start/stop pair placed across the counter wrap catches an interval done in plain rather than modular arithmetic. Flipping the mode bit right after a conversion, writing to out-of-range addresses and writing the other channel's table expose a design that reads live configuration late or decodes writes loosely. A simultaneous start and stop shows whether the interval pairs with the stale start. Back-to-back strobes show whether a pipeline stage drops or merges results.

// File: rtl/hta_pkg.sv
package hta_pkg;
  typedef enum logic {TBL_FINE = 1'b0, TBL_ULTRA = 1'b1} tbl_e;
  localparam int FRAC_BITS = 4;
endpackage

// File: rtl/hta_coarse_ctr.sv
module hta_coarse_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt
);
  logic running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      running <= 1'b1;
    end
  end

  // R1: counter steps by one each clock, wrapping modulo 2^CW
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt == CW'($past(cnt) + 1'b1)));
endmodule

// File: rtl/hta_cal_tables.sv
module hta_cal_tables #(
  parameter int          WW        = 16,
  parameter int          UW        = 5,
  parameter int          UBINS     = 27,
  parameter int          FBINS     = 4,
  parameter int          FIW       = 2,
  parameter int          SW        = 21,
  parameter logic [15:0] FINE_RST  = 16'd8000,
  parameter logic [15:0] ULTRA_RST = 16'd320
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_ultra,
  input  logic [UW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic [FIW-1:0] f_code,
  input  logic          slow,
  input  logic [UW-1:0] u_code,
  output logic [SW-1:0] fine_sum,
  output logic [SW-1:0] ultra_term
);
  logic [FBINS-1:0][WW-1:0] fw;
  logic [UBINS-1:0][WW-1:0] uw;
  logic [FBINS:0][SW-1:0]   fpre;
  logic [UBINS:0][SW-1:0]   upre;
  logic [FIW:0]             fidx;
  logic [UW-1:0]            uclamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < FBINS; k++) fw[k] <= WW'(FINE_RST);
      for (int k = 0; k < UBINS; k++) uw[k] <= WW'(ULTRA_RST);
    end else if (wr_en) begin
      if (!wr_ultra) begin
        for (int k = 0; k < FBINS; k++)
          if (wr_addr == UW'(k)) fw[k] <= wr_data;
      end else begin
        for (int k = 0; k < UBINS; k++)
          if (wr_addr == UW'(k)) uw[k] <= wr_data;
      end
    end
  end

  // running sums of calibrated widths: entry k covers bins below k
  always_comb begin
    fpre[0] = '0;
    for (int k = 0; k < FBINS; k++) fpre[k+1] = fpre[k] + SW'(fw[k]);
    upre[0] = '0;
    for (int k = 0; k < UBINS; k++) upre[k+1] = upre[k] + SW'(uw[k]);
  end

  always_comb begin
    fidx = {1'b0, f_code} + {{FIW{1'b0}}, slow};
    fine_sum = '0;
    for (int k = 0; k <= FBINS; k++)
      if (fidx == (FIW+1)'(k)) fine_sum = fpre[k];
    uclamp = (u_code > UW'(UBINS)) ? UW'(UBINS) : u_code;
    ultra_term = '0;
    for (int k = 1; k <= UBINS; k++)
      if (uclamp == UW'(k)) ultra_term = upre[k-1] + SW'(uw[k-1] >> 1);
  end

  // R6: tables only change on a write aimed at this channel
  p_tbl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(fw) && $stable(uw)));
endmodule

// File: rtl/hta_channel.sv
module hta_channel #(
  parameter int          CW        = 16,
  parameter int          UW        = 5,
  parameter int          WW        = 16,
  parameter int          UBINS     = 27,
  parameter int          FBINS     = 4,
  parameter int          FIW       = 2,
  parameter int          SW        = 21,
  parameter int          FPW       = 23,
  parameter int          TSW       = 32,
  parameter int          TCLK_Q    = 32000,
  parameter logic [15:0] FINE_RST  = 16'd8000,
  parameter logic [15:0] ULTRA_RST = 16'd320
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         cnt,
  input  logic                  eoc,
  input  logic [FIW-1:0]        f_code,
  input  logic [UW-1:0]         u_code,
  input  logic                  slow_cfg,
  input  logic                  wr_en,
  input  logic                  wr_ultra,
  input  logic [UW-1:0]         wr_addr,
  input  logic [WW-1:0]         wr_data,
  output logic                  st2_valid,
  output logic [CW-1:0]         st2_coarse,
  output logic signed [FPW-1:0] st2_frac,
  output logic                  ts_valid,
  output logic [TSW-1:0]        ts
);
  function automatic logic signed [FPW-1:0] merge_frac(
      input logic [SW-1:0] fs, input logic [SW-1:0] ut, input logic sl);
    logic signed [FPW-1:0] a, b;
    a = $signed({2'b00, fs});
    b = $signed({2'b00, ut});
    return sl ? (a - b) : (a + b);
  endfunction

  function automatic logic [TSW-1:0] place_ts(
      input logic [CW-1:0] c, input logic signed [FPW-1:0] fp);
    return TSW'(c) * TSW'(TCLK_Q) + TSW'(fp);
  endfunction

  logic [SW-1:0] fine_sum, ultra_term;
  logic          cap_evt;
  logic          s1_v, s1_slow;
  logic [CW-1:0] s1_c;
  logic [SW-1:0] s1_f, s1_u;
  logic [1:0]    age;

  assign cap_evt = eoc;

  hta_cal_tables #(
    .WW(WW), .UW(UW), .UBINS(UBINS), .FBINS(FBINS), .FIW(FIW), .SW(SW),
    .FINE_RST(FINE_RST), .ULTRA_RST(ULTRA_RST)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ultra(wr_ultra),
    .wr_addr(wr_addr), .wr_data(wr_data), .f_code(f_code), .slow(slow_cfg),
    .u_code(u_code), .fine_sum(fine_sum), .ultra_term(ultra_term)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_slow <= 1'b0; s1_c <= '0; s1_f <= '0; s1_u <= '0;
      st2_valid <= 1'b0; st2_coarse <= '0; st2_frac <= '0;
      ts_valid <= 1'b0; ts <= '0;
      age <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      s1_v <= cap_evt;
      if (cap_evt) begin
        s1_c    <= cnt - CW'(u_code);
        s1_f    <= fine_sum;
        s1_u    <= ultra_term;
        s1_slow <= slow_cfg;
      end
      st2_valid <= s1_v;
      if (s1_v) begin
        st2_coarse <= s1_c;
        st2_frac   <= merge_frac(s1_f, s1_u, s1_slow);
      end
      ts_valid <= st2_valid;
      if (st2_valid) ts <= place_ts(st2_coarse, st2_frac);
    end
  end

  // R2: exactly one strobe, three edges after each sampled end-of-conversion
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (ts_valid == $past(eoc, 3)));
endmodule

// File: rtl/hit_timestamp_assembler.sv
module hit_timestamp_assembler
  import hta_pkg::*;
#(
  parameter int CW           = 16,
  parameter int UW           = 5,
  parameter int WW           = 16,
  parameter int UBINS        = 27,
  parameter int FBINS        = 4,
  parameter int TCLK_PS      = 2000,
  parameter int NOM_FINE_PS  = 500,
  parameter int NOM_ULTRA_PS = 20
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         cfg_slow,
  input  logic                                         start_eoc,
  input  logic [$clog2(FBINS)-1:0]                     start_fine,
  input  logic [UW-1:0]                                start_ufc,
  input  logic                                         stop_eoc,
  input  logic [$clog2(FBINS)-1:0]                     stop_fine,
  input  logic [UW-1:0]                                stop_ufc,
  input  logic                                         cal_we,
  input  logic                                         cal_chan,
  input  logic                                         cal_tbl,
  input  logic [UW-1:0]                                cal_addr,
  input  logic [WW-1:0]                                cal_data,
  output logic                                         start_ts_valid,
  output logic [CW+$clog2(TCLK_PS << FRAC_BITS):0]     start_ts,
  output logic                                         stop_ts_valid,
  output logic [CW+$clog2(TCLK_PS << FRAC_BITS):0]     stop_ts,
  output logic                                         iv_valid,
  output logic [CW+$clog2(TCLK_PS << FRAC_BITS)+1:0]   iv
);
  localparam int FIW    = $clog2(FBINS);
  localparam int SW     = WW + UW;
  localparam int FPW    = SW + 2;
  localparam int TCLK_Q = TCLK_PS << FRAC_BITS;
  localparam int TSW    = CW + $clog2(TCLK_Q) + 1;
  localparam int IW     = TSW + 1;
  localparam logic [15:0] FINE_RST  = 16'(NOM_FINE_PS << FRAC_BITS);
  localparam logic [15:0] ULTRA_RST = 16'(NOM_ULTRA_PS << FRAC_BITS);

  function automatic logic [IW-1:0] span(
      input logic [CW-1:0] a_c, input logic signed [FPW-1:0] a_fp,
      input logic [CW-1:0] b_c, input logic signed [FPW-1:0] b_fp);
    logic [CW-1:0] dc;
    dc = a_c - b_c;
    return IW'(dc) * IW'(TCLK_Q) + IW'(a_fp) - IW'(b_fp);
  endfunction

  logic [CW-1:0]         cnt;
  logic [1:0]            ch_eoc;
  logic [FIW-1:0]        ch_f   [2];
  logic [UW-1:0]         ch_u   [2];
  logic [1:0]            ch_s2v;
  logic [CW-1:0]         ch_s2c [2];
  logic signed [FPW-1:0] ch_s2f [2];
  logic [1:0]            ch_tsv;
  logic [TSW-1:0]        ch_ts  [2];
  logic                  wr_ultra;

  assign ch_eoc   = {stop_eoc, start_eoc};
  assign ch_f[0]  = start_fine;
  assign ch_f[1]  = stop_fine;
  assign ch_u[0]  = start_ufc;
  assign ch_u[1]  = stop_ufc;
  assign wr_ultra = (cal_tbl == TBL_ULTRA);

  hta_coarse_ctr #(.CW(CW)) u_ctr (.clk(clk), .rst_n(rst_n), .cnt(cnt));

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    hta_channel #(
      .CW(CW), .UW(UW), .WW(WW), .UBINS(UBINS), .FBINS(FBINS), .FIW(FIW),
      .SW(SW), .FPW(FPW), .TSW(TSW), .TCLK_Q(TCLK_Q),
      .FINE_RST(FINE_RST), .ULTRA_RST(ULTRA_RST)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .eoc(ch_eoc[ch]),
      .f_code(ch_f[ch]), .u_code(ch_u[ch]), .slow_cfg(cfg_slow),
      .wr_en(cal_we && (cal_chan == 1'(ch))), .wr_ultra(wr_ultra),
      .wr_addr(cal_addr), .wr_data(cal_data),
      .st2_valid(ch_s2v[ch]), .st2_coarse(ch_s2c[ch]), .st2_frac(ch_s2f[ch]),
      .ts_valid(ch_tsv[ch]), .ts(ch_ts[ch])
    );
  end

  assign start_ts_valid = ch_tsv[0];
  assign start_ts       = ch_ts[0];
  assign stop_ts_valid  = ch_tsv[1];
  assign stop_ts        = ch_ts[1];

  // interval pairing: newest start, bypassing the held copy when simultaneous
  logic [CW-1:0]         held_c, ref_c;
  logic signed [FPW-1:0] held_f, ref_f;
  logic                  iv_fire;

  assign ref_c   = ch_s2v[0] ? ch_s2c[0] : held_c;
  assign ref_f   = ch_s2v[0] ? ch_s2f[0] : held_f;
  assign iv_fire = ch_s2v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_c <= '0; held_f <= '0; iv_valid <= 1'b0; iv <= '0;
    end else begin
      if (ch_s2v[0]) begin
        held_c <= ch_s2c[0];
        held_f <= ch_s2f[0];
      end
      iv_valid <= iv_fire;
      if (iv_fire) iv <= span(ch_s2c[1], ch_s2f[1], ref_c, ref_f);
    end
  end

  // R7: an interval accompanies every stop timestamp and nothing else
  p_iv_with_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iv_valid == stop_ts_valid);
endmodule

// File: tb/sim_hit_timestamp_assembler.sv
module sim_hit_timestamp_assembler;
  localparam int CLK_PERIOD = 10;
  localparam int CMOD  = 65536;
  localparam int TQ    = 32000;
  localparam int UBINS = 27;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_slow = 1'b0, start_eoc = 1'b0, stop_eoc = 1'b0;
  logic [1:0] start_fine = '0, stop_fine = '0;
  logic [4:0] start_ufc = '0, stop_ufc = '0, cal_addr = '0;
  logic cal_we = 1'b0, cal_chan = 1'b0, cal_tbl = 1'b0;
  logic [15:0] cal_data = '0;
  logic start_ts_valid, stop_ts_valid, iv_valid;
  logic [31:0] start_ts, stop_ts;
  logic [32:0] iv;

  hit_timestamp_assembler u0 (
    .clk(clk), .rst_n(rst_n), .cfg_slow(cfg_slow),
    .start_eoc(start_eoc), .start_fine(start_fine), .start_ufc(start_ufc),
    .stop_eoc(stop_eoc), .stop_fine(stop_fine), .stop_ufc(stop_ufc),
    .cal_we(cal_we), .cal_chan(cal_chan), .cal_tbl(cal_tbl),
    .cal_addr(cal_addr), .cal_data(cal_data),
    .start_ts_valid(start_ts_valid), .start_ts(start_ts),
    .stop_ts_valid(stop_ts_valid), .stop_ts(stop_ts),
    .iv_valid(iv_valid), .iv(iv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, nc = 0, mk;
  bit done = 0, mon_on = 0;
  int bcnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= 0; else bcnt <= (bcnt + 1) % CMOD;

  int unsigned bfw[2][4];
  int unsigned buw[2][UBINS];
  bit es_v[8], ep_v[8];
  bit [31:0] es_ts[8], ep_ts[8];
  bit [32:0] ei[8];
  string tg_s[8], tg_p[8];
  int ls_c = 0;
  longint ls_f = 0;

  function automatic longint f_part(int ch, int k);
    longint s = 0;
    for (int j = 0; j < k; j++) s += bfw[ch][j];
    return s;
  endfunction

  function automatic longint u_part(int ch, int u);
    longint s = 0;
    int uu = (u > UBINS) ? UBINS : u;
    if (uu == 0) return 0;
    for (int j = 0; j < uu - 1; j++) s += buw[ch][j];
    return s + buw[ch][uu-1] / 2;
  endfunction

  function automatic longint frac_of(int ch, int f, int u, bit sl);
    return sl ? f_part(ch, f + 1) - u_part(ch, u) : f_part(ch, f) + u_part(ch, u);
  endfunction

  function automatic bit [31:0] ts_of(int c, longint fr);
    longint t = longint'(c) * TQ + fr;
    return 32'(t);
  endfunction

  function automatic bit [32:0] iv_of(int cs, longint fs, int cb, longint fb);
    longint t = longint'((cs - cb + CMOD) % CMOD) * TQ + fs - fb;
    return 33'(t);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // scoreboard monitor, sampling between edges
  always @(negedge clk) begin
    mk = nc % 8;
    if (mon_on) begin
      if (es_v[mk] || start_ts_valid) begin
        n_chk++;
        if (start_ts_valid !== es_v[mk]) begin
          n_bad++; $display("FAIL R2 start valid: got %b exp %b", start_ts_valid, es_v[mk]);
        end else if (start_ts !== es_ts[mk]) begin
          n_bad++; $display("FAIL %s start ts: got %h exp %h", tg_s[mk], start_ts, es_ts[mk]);
        end
      end
      if (ep_v[mk] || stop_ts_valid || iv_valid) begin
        n_chk++;
        if (stop_ts_valid !== ep_v[mk]) begin
          n_bad++; $display("FAIL R2 stop valid: got %b exp %b", stop_ts_valid, ep_v[mk]);
        end else if (stop_ts !== ep_ts[mk]) begin
          n_bad++; $display("FAIL %s stop ts: got %h exp %h", tg_p[mk], stop_ts, ep_ts[mk]);
        end
        n_chk++;
        if (iv_valid !== ep_v[mk]) begin
          n_bad++; $display("FAIL R7 iv valid: got %b exp %b", iv_valid, ep_v[mk]);
        end else if (ep_v[mk] && iv !== ei[mk]) begin
          n_bad++; $display("FAIL R7 interval (%s): got %h exp %h", tg_p[mk], iv, ei[mk]);
        end
      end
    end
    es_v[mk] = 0; ep_v[mk] = 0;
    nc++;
  end

  task automatic convert(bit ds, bit dp, int fs, int us, int fp, int up, bit sl, string tg);
    int slot, cc;
    longint fr;
    @(negedge clk); #1;
    start_eoc = ds; stop_eoc = dp; cfg_slow = sl;
    start_fine = 2'(fs); start_ufc = 5'(us); stop_fine = 2'(fp); stop_ufc = 5'(up);
    slot = (nc + 2) % 8;
    if (ds) begin
      cc = (bcnt - us + CMOD) % CMOD; fr = frac_of(0, fs, us, sl);
      es_v[slot] = 1; es_ts[slot] = ts_of(cc, fr); tg_s[slot] = tg;
      ls_c = cc; ls_f = fr;
    end
    if (dp) begin
      cc = (bcnt - up + CMOD) % CMOD; fr = frac_of(1, fp, up, sl);
      ep_v[slot] = 1; ep_ts[slot] = ts_of(cc, fr); tg_p[slot] = tg;
      ei[slot] = iv_of(cc, fr, ls_c, ls_f);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      start_eoc = 0; stop_eoc = 0;
    end
  endtask

  task automatic cal_write(int ch, int tbl, int addr, int data);
    @(negedge clk); #1;
    start_eoc = 0; stop_eoc = 0;
    cal_we = 1; cal_chan = 1'(ch); cal_tbl = 1'(tbl);
    cal_addr = 5'(addr); cal_data = 16'(data);
    if (tbl == 0 && addr < 4) bfw[ch][addr] = data;
    if (tbl == 1 && addr < UBINS) buw[ch][addr] = data;
    @(negedge clk); #1;
    cal_we = 0;
  endtask

  task automatic chk_reset(string what, longint got);
    n_chk++;
    if (got != 0) begin
      n_bad++; $display("FAIL R2 reset %s: got %0d exp 0", what, got);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 2; c++) begin
      for (int j = 0; j < 4; j++) bfw[c][j] = 8000;
      for (int j = 0; j < UBINS; j++) buw[c][j] = 320;
    end
    repeat (4) @(negedge clk);
    chk_reset("start_ts_valid", start_ts_valid);
    chk_reset("stop_ts_valid", stop_ts_valid);
    chk_reset("iv_valid", iv_valid);
    chk_reset("start_ts", start_ts);
    chk_reset("iv", iv);
    #1 rst_n = 1; mon_on = 1;

    // R1: c - u goes negative right after reset and must wrap
    convert(1, 0, 1, 20, 0, 0, 0, "R1");
    idle(3);
    // R3 nominal fast mode, R7 interval
    convert(1, 0, 2, 10, 0, 0, 0, "R3");
    idle(4);
    convert(0, 1, 0, 0, 3, 5, 0, "R3");
    idle(4);
    // R4 slow mode
    convert(1, 0, 3, 7, 0, 0, 1, "R4");
    idle(2);
    convert(0, 1, 0, 0, 0, 27, 1, "R4");
    idle(4);
    // R5 clamp and zero
    convert(1, 1, 1, 0, 2, 31, 0, "R5");
    convert(1, 1, 0, 28, 3, 27, 1, "R5");
    idle(4);
    // R6 calibration writes, out-of-range ignored, other channel untouched
    cal_write(0, 0, 1, 7000);
    cal_write(0, 1, 4, 400);
    cal_write(0, 0, 6, 100);
    cal_write(0, 1, 29, 100);
    cal_write(1, 1, 0, 900);
    convert(1, 0, 2, 6, 0, 0, 0, "R6");
    idle(1);
    convert(1, 1, 2, 6, 2, 6, 1, "R6");
    idle(4);
    // R8 mode bit flips right after the strobe
    convert(1, 1, 1, 9, 2, 12, 1, "R8");
    @(negedge clk); #1; start_eoc = 0; stop_eoc = 0; cfg_slow = 0;
    idle(4);
    // R9 back-to-back conversions
    for (int i = 0; i < 6; i++)
      convert(1, i % 2 == 1, i % 4, 3 + i, (i + 1) % 4, 20 - i, i % 3 == 0, "R9");
    idle(4);
    // randomized mix
    for (int i = 0; i < 400; i++) begin
      bit sl = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0)
        cal_write($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 31),
                  $urandom_range(100, 9000));
      convert(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              $urandom_range(0, 3), $urandom_range(0, 31),
              $urandom_range(0, 3), $urandom_range(0, 31), sl, sl ? "R4" : "R3");
      idle($urandom_range(0, 2));
    end
    idle(4);
    // R1 / R7: interval across the coarse counter wrap
    while (bcnt != CMOD - 6) idle(1);
    convert(1, 0, 1, 3, 0, 0, 0, "R1");
    idle(8);
    convert(0, 1, 0, 0, 2, 5, 0, "R1");
    idle(6);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: got still running exp finished");
      summary();
      $finish;
    end
  end
endmodule